// File: doc/BRIEF.md
# Program Flash Self-Programming Read and Block-Erase Controller

This block sits between a small processor core and its own program flash. Software uses it to fetch one program word as data, or to wipe one aligned 32-word block of program memory. It works through a set of byte-wide registers on a simple bus: address, write data, write strobe and combinational read data. The core side gets two signals. One discards the instruction fetched in a given cycle. The other holds instruction execution while an erase is in progress. The clock and all other logic keep running during that hold. The array side gets a one-cycle read strobe, a level-held block-erase request and a word address. The array returns the word combinationally and may signal completion early.

Erase is guarded by a key sequence. Software writes 55h and then AAh to a key register. The very next bus write must be the one that sets the start bit. Any other write in between cancels the key. A start that is not properly keyed or enabled does nothing except raise an error flag. One bus cycle is one instruction cycle.

Top module: `pflash_selfprog_ctrl`

## Requirements
- R1: After reset, every register reads 00h, and core_kill, core_stall, fl_rd and fl_erase are low.
- R2: Register offsets are 0 = address low byte, 1 = address high byte, 2 = data low byte, 3 = data high byte, 4 = control, 5 = key. A control write with bit 7 (program select) and bit 0 (read start) set is followed, in the next cycle only, by fl_rd high, fl_addr equal to {high,low} and core_kill high for exactly that one cycle.
- R3: From the cycle after the access, the data low register holds word bits 7:0 and the data high register holds word bits 13:8 in its bits 5:0, with its bits 7:6 reading 0. The read-start bit reads back 0 again.
- R4: A control write with bit 0 set but bit 7 clear starts no access: no fl_rd, no core_kill, the data registers are unchanged, and bit 0 reads back 0.
- R5: Software writes to the data registers take effect and hold until the next read or write of them. Only 6 bits of the high byte are stored.
- R6: An erase drives fl_addr with address bits 4:0 forced to zero. Afterwards, all 32 words of that block read 3FFFh and the words on either side keep their contents.
- R7: Writing 55h and then AAh to the key register, with the next bus write being a control write with bits 7, 4 (erase select), 2 (write enable) and 1 (start) all set, starts the erase. Bit 1 then reads 1.
- R8: Any bus write between the two key bytes, or a wrong second byte, cancels the key, and a following start is refused.
- R9: A refused start (no valid key, or bit 2 or bit 4 clear) leaves bit 1 at 0 and raises no core_kill or core_stall. It sets error bit 3. Every control write loads bit 3 from the written data, OR-ed with a new error.
- R10: An accepted start gives two cycles of core_kill. Then core_stall and fl_erase stay high together until fl_done, or for ERASE_CYCLES cycles if fl_done never comes. Bit 1 then reads 0.
- R11: The key register and the unused offsets 6 and 7 always read 00h.
- R12: A key pair is consumed by the write that follows it, so a second start without a fresh pair is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data (combinational) |
| core_kill | output | 1 | Discard the instruction fetched this cycle |
| core_stall | output | 1 | Hold instruction execution |
| fl_rd | output | 1 | Array read strobe |
| fl_erase | output | 1 | Array block-erase request |
| fl_addr | output | ADDR_W | Array word address |
| fl_rdata | input | DATA_W | Array read word |
| fl_done | input | 1 | Array reports erase finished |

## Verification
The hardest states to reach are the exact edges of the key sequence: a key that has been half written, then broken by an unrelated write or a wrong byte, and a key that was already used up by an accepted erase. The bench walks each of these by issuing bus writes in a precise order. After every refused start it reads the control byte to see the error and start bits, and it watches the core signals for a few cycles. A behavioural array model counts the stall length in two cases, with an early done and with none. It then reads back the erased block and both of its neighbours through the normal read path.

// File: rtl/pfsp_pkg.sv
package pfsp_pkg;
  localparam int BUS_AW = 3;
  localparam int BUS_DW = 8;

  localparam logic [BUS_AW-1:0] RA_ADDR_LO = 3'd0;
  localparam logic [BUS_AW-1:0] RA_ADDR_HI = 3'd1;
  localparam logic [BUS_AW-1:0] RA_DATA_LO = 3'd2;
  localparam logic [BUS_AW-1:0] RA_DATA_HI = 3'd3;
  localparam logic [BUS_AW-1:0] RA_CTRL    = 3'd4;
  localparam logic [BUS_AW-1:0] RA_KEY     = 3'd5;

  localparam logic [BUS_DW-1:0] KEY_FIRST  = 8'h55;
  localparam logic [BUS_DW-1:0] KEY_SECOND = 8'hAA;

  localparam int CB_READ  = 0;
  localparam int CB_START = 1;
  localparam int CB_WEN   = 2;
  localparam int CB_ERR   = 3;
  localparam int CB_ERASE = 4;
  localparam int CB_PSEL  = 7;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD,
    SQ_SU1,
    SQ_SU2,
    SQ_RUN
  } sq_state_e;

  typedef enum logic [1:0] {
    UL_IDLE,
    UL_HALF,
    UL_ARMED
  } ul_state_e;
endpackage

// File: rtl/pfsp_unlock.sv
module pfsp_unlock
  import pfsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic              armed
);
  ul_state_e state_q, state_d;
  logic      key_wr;

  assign key_wr = bus_we && (bus_addr == RA_KEY);

  always_comb begin
    state_d = state_q;
    if (bus_we) begin
      unique case (state_q)
        UL_IDLE:  state_d = (key_wr && bus_wdata == KEY_FIRST)  ? UL_HALF  : UL_IDLE;
        UL_HALF:  state_d = (key_wr && bus_wdata == KEY_SECOND) ? UL_ARMED : UL_IDLE;
        UL_ARMED: state_d = UL_IDLE;
        default:  state_d = UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UL_IDLE;
    end else if (bus_we) begin
      state_q <= state_d;
    end
  end

  assign armed = (state_q == UL_ARMED);
endmodule

// File: rtl/pfsp_seq.sv
module pfsp_seq
  import pfsp_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int BLK_WORDS    = 32,
  parameter int ERASE_CYCLES = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic              er_go,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              fl_done,
  output logic              fl_rd,
  output logic              fl_erase,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              core_kill,
  output logic              core_stall,
  output logic              cap_en,
  output logic              er_end,
  output logic              busy
);
  localparam int              CNT_W    = $clog2(ERASE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'(BLK_WORDS - 1);

  sq_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic [ADDR_W-1:0] lat_q, lat_d;
  logic              lat_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    er_end  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (er_go)      state_d = SQ_SU1;
        else if (rd_go) state_d = SQ_RD;
      end
      SQ_RD:  state_d = SQ_IDLE;
      SQ_SU1: state_d = SQ_SU2;
      SQ_SU2: begin
        state_d = SQ_RUN;
        cnt_d   = '0;
      end
      SQ_RUN: begin
        if (fl_done || cnt_q == CNT_LAST) begin
          state_d = SQ_IDLE;
          er_end  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  assign cnt_en = (state_q == SQ_SU2) || (state_q == SQ_RUN);
  assign lat_en = (state_q == SQ_IDLE) && (er_go || rd_go);
  assign lat_d  = er_go ? (addr_q & ~BLK_MASK) : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      lat_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (lat_en) lat_q <= lat_d;
    end
  end

  assign fl_rd      = (state_q == SQ_RD);
  assign fl_erase   = (state_q == SQ_RUN);
  assign core_stall = (state_q == SQ_RUN);
  assign core_kill  = (state_q == SQ_RD) || (state_q == SQ_SU1) || (state_q == SQ_SU2);
  assign cap_en     = (state_q == SQ_RD);
  assign busy       = (state_q != SQ_IDLE);
  assign fl_addr    = lat_q;
endmodule

// File: rtl/pfsp_regs.sv
module pfsp_regs
  import pfsp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic              armed,
  input  logic              busy,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              er_end,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rd_go,
  output logic              er_go
);
  localparam int AH_W = ADDR_W - BUS_DW;
  localparam int DH_W = DATA_W - BUS_DW;

  logic [BUS_DW-1:0] alo_q, dlo_q, dlo_d;
  logic [AH_W-1:0]   ahi_q;
  logic [DH_W-1:0]   dhi_q, dhi_d;
  logic              psel_q, esel_q, wen_q, err_q, wr_q, rd_q;
  logic              err_d, wr_d, rd_d;
  logic              alo_en, ahi_en, dlo_en, dhi_en, ctrl_we;
  logic              start_req, start_ok, read_ok;
  logic [BUS_DW-1:0] ctrl_view;

  assign alo_en  = bus_we && bus_addr == RA_ADDR_LO;
  assign ahi_en  = bus_we && bus_addr == RA_ADDR_HI;
  assign dlo_en  = cap_en || (bus_we && bus_addr == RA_DATA_LO);
  assign dhi_en  = cap_en || (bus_we && bus_addr == RA_DATA_HI);
  assign ctrl_we = bus_we && bus_addr == RA_CTRL && !busy;

  assign start_req = ctrl_we && bus_wdata[CB_START];
  assign start_ok  = start_req && armed && bus_wdata[CB_PSEL]
                     && bus_wdata[CB_WEN] && bus_wdata[CB_ERASE];
  assign read_ok   = ctrl_we && bus_wdata[CB_READ] && bus_wdata[CB_PSEL]
                     && !bus_wdata[CB_START];

  always_comb begin
    dlo_d = cap_en ? cap_data[BUS_DW-1:0] : bus_wdata;
    dhi_d = cap_en ? cap_data[DATA_W-1:BUS_DW] : bus_wdata[DH_W-1:0];
    err_d = ctrl_we ? (bus_wdata[CB_ERR] | (start_req & ~start_ok)) : err_q;
    wr_d  = start_ok ? 1'b1 : (er_end ? 1'b0 : wr_q);
    rd_d  = read_ok  ? 1'b1 : (cap_en ? 1'b0 : rd_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alo_q  <= '0;
      ahi_q  <= '0;
      dlo_q  <= '0;
      dhi_q  <= '0;
      psel_q <= 1'b0;
      esel_q <= 1'b0;
      wen_q  <= 1'b0;
      err_q  <= 1'b0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      if (alo_en) alo_q <= bus_wdata;
      if (ahi_en) ahi_q <= bus_wdata[AH_W-1:0];
      if (dlo_en) dlo_q <= dlo_d;
      if (dhi_en) dhi_q <= dhi_d;
      if (ctrl_we) begin
        psel_q <= bus_wdata[CB_PSEL];
        esel_q <= bus_wdata[CB_ERASE];
        wen_q  <= bus_wdata[CB_WEN];
      end
      err_q <= err_d;
      wr_q  <= wr_d;
      rd_q  <= rd_d;
    end
  end

  always_comb begin
    ctrl_view           = '0;
    ctrl_view[CB_PSEL]  = psel_q;
    ctrl_view[CB_ERASE] = esel_q;
    ctrl_view[CB_ERR]   = err_q;
    ctrl_view[CB_WEN]   = wen_q;
    ctrl_view[CB_START] = wr_q;
    ctrl_view[CB_READ]  = rd_q;
  end

  always_comb begin
    unique case (bus_addr)
      RA_ADDR_LO: bus_rdata = alo_q;
      RA_ADDR_HI: bus_rdata = BUS_DW'(ahi_q);
      RA_DATA_LO: bus_rdata = dlo_q;
      RA_DATA_HI: bus_rdata = BUS_DW'(dhi_q);
      RA_CTRL:    bus_rdata = ctrl_view;
      default:    bus_rdata = '0;
    endcase
  end

  assign addr_q = {ahi_q, alo_q};
  assign rd_go  = read_ok;
  assign er_go  = start_ok;
endmodule

// File: rtl/pflash_selfprog_ctrl.sv
module pflash_selfprog_ctrl
  import pfsp_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 14,
  parameter int BLK_WORDS    = 32,
  parameter int ERASE_CYCLES = 100000,
  parameter int RST_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  output logic [7:0]        reg_rdata,
  output logic              core_kill,
  output logic              core_stall,
  output logic              fl_rd,
  output logic              fl_erase,
  output logic [ADDR_W-1:0] fl_addr,
  input  logic [DATA_W-1:0] fl_rdata,
  input  logic              fl_done
);
  localparam int BLK_OFS_W = $clog2(BLK_WORDS);

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[RST_STAGES-1];

  logic              armed, busy, cap_en, er_end, rd_go, er_go;
  logic [ADDR_W-1:0] addr_q;

  pfsp_unlock u_unlock (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_we    (reg_we),
    .bus_addr  (reg_addr),
    .bus_wdata (reg_wdata),
    .armed     (armed)
  );

  pfsp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_we    (reg_we),
    .bus_addr  (reg_addr),
    .bus_wdata (reg_wdata),
    .bus_rdata (reg_rdata),
    .armed     (armed),
    .busy      (busy),
    .cap_en    (cap_en),
    .cap_data  (fl_rdata),
    .er_end    (er_end),
    .addr_q    (addr_q),
    .rd_go     (rd_go),
    .er_go     (er_go)
  );

  pfsp_seq #(
    .ADDR_W       (ADDR_W),
    .BLK_WORDS    (BLK_WORDS),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .rd_go      (rd_go),
    .er_go      (er_go),
    .addr_q     (addr_q),
    .fl_done    (fl_done),
    .fl_rd      (fl_rd),
    .fl_erase   (fl_erase),
    .fl_addr    (fl_addr),
    .core_kill  (core_kill),
    .core_stall (core_stall),
    .cap_en     (cap_en),
    .er_end     (er_end),
    .busy       (busy)
  );
endmodule

// File: rtl/pflash_selfprog_ctrl_chk.sv
module pflash_selfprog_ctrl_chk #(
  parameter int OFS_W        = 5,
  parameter int ERASE_CYCLES = 100000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       reg_addr,
  input logic [7:0]       reg_rdata,
  input logic             core_kill,
  input logic             core_stall,
  input logic             fl_rd,
  input logic             fl_erase,
  input logic [OFS_W-1:0] blk_ofs
);
  logic [31:0] stall_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stall_run <= '0;
    else if (core_stall) stall_run <= stall_run + 1'b1;
    else                 stall_run <= '0;
  end

  assert_read_kills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd |-> core_kill);

  assert_read_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd |=> (!fl_rd && !core_kill));

  assert_block_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase |-> (blk_ofs == '0));

  assert_setup_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_stall) |-> $past(core_kill));

  assert_stall_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> (fl_erase && !core_kill && !fl_rd));

  assert_stall_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> (stall_run < ERASE_CYCLES));

  assert_kill_then_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(core_kill) && !$past(fl_rd)) |-> core_stall);

  assert_key_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd5) |-> (reg_rdata == 8'h00));
endmodule

bind pflash_selfprog_ctrl pflash_selfprog_ctrl_chk #(
  .OFS_W        (BLK_OFS_W),
  .ERASE_CYCLES (ERASE_CYCLES)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .core_kill  (core_kill),
  .core_stall (core_stall),
  .fl_rd      (fl_rd),
  .fl_erase   (fl_erase),
  .blk_ofs    (fl_addr[BLK_OFS_W-1:0])
);

// File: tb/pflash_selfprog_ctrl_tb_top.sv
module pflash_selfprog_ctrl_tb_top;
  localparam int EC = 40;

  logic        clk;
  logic        rst_n;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic        reg_we;
  logic [7:0]  reg_rdata;
  logic        core_kill, core_stall, fl_rd, fl_erase, fl_done;
  logic [15:0] fl_addr;
  logic [13:0] fl_rdata;

  int total = 0;
  int bad   = 0;
  int done_at = 0;

  pflash_selfprog_ctrl #(.ERASE_CYCLES(EC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .core_kill(core_kill),
    .core_stall(core_stall), .fl_rd(fl_rd), .fl_erase(fl_erase),
    .fl_addr(fl_addr), .fl_rdata(fl_rdata), .fl_done(fl_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [13:0] pat(logic [15:0] a);
    logic [31:0] v;
    v = 32'(a[9:0]) * 32'd37 + 32'd5;
    return v[13:0];
  endfunction

  // behavioural array: 32 blocks of 32 words, aliased over the address space
  logic [31:0] erased;
  int          ecnt;
  assign fl_rdata = erased[fl_addr[9:5]] ? 14'h3FFF : pat(fl_addr);
  assign fl_done  = fl_erase && (done_at != 0) && (ecnt == done_at - 1);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erased <= '0;
      ecnt   <= 0;
    end else if (fl_erase) begin
      ecnt <= ecnt + 1;
      if (ecnt == 0) erased[fl_addr[9:5]] <= 1'b1;
    end else begin
      ecnt <= 0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_read(logic [15:0] a, logic [13:0] exp);
    logic [7:0] lo, hi, c;
    bus_wr(3'd0, a[7:0]);
    bus_wr(3'd1, a[15:8]);
    bus_wr(3'd4, 8'h81);
    chk("R2 fl_rd", 32'(fl_rd), 32'd1);
    chk("R2 fl_addr", 32'(fl_addr), 32'(a));
    chk("R2 kill", 32'(core_kill), 32'd1);
    @(negedge clk);
    chk("R2 kill one cycle", 32'(core_kill), 32'd0);
    bus_rd(3'd2, lo);
    bus_rd(3'd3, hi);
    bus_rd(3'd4, c);
    chk("R3 data word", 32'({hi, lo}), 32'({2'b00, exp}));
    chk("R3 read bit clear", 32'(c), 32'h80);
  endtask

  task automatic do_erase(logic [15:0] a, int dly, int exp_n);
    logic [7:0] c;
    int n;
    done_at = dly;
    bus_wr(3'd0, a[7:0]);
    bus_wr(3'd1, a[15:8]);
    bus_wr(3'd5, 8'h55);
    bus_wr(3'd5, 8'hAA);
    bus_wr(3'd4, 8'h96);
    chk("R10 setup1 kill", 32'({core_kill, core_stall}), 32'b10);
    bus_rd(3'd4, c);
    chk("R7 start bit set", 32'(c[1]), 32'd1);
    @(negedge clk);
    chk("R10 setup2 kill", 32'({core_kill, core_stall}), 32'b10);
    @(negedge clk);
    chk("R10 stall+erase", 32'({core_stall, fl_erase, core_kill}), 32'b110);
    chk("R6 block addr", 32'(fl_addr), 32'({a[15:5], 5'd0}));
    n = 0;
    while (core_stall && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R10 stall length", 32'(n), 32'(exp_n));
    bus_rd(3'd4, c);
    chk("R10 start bit cleared", 32'(c), 32'h94);
  endtask

  task automatic refused(string req, logic [7:0] exp_ctrl);
    logic [7:0] c;
    chk({req, " no kill"}, 32'({core_kill, core_stall}), 32'b00);
    @(negedge clk);
    chk({req, " no stall"}, 32'({core_kill, core_stall, fl_erase}), 32'b000);
    bus_rd(3'd4, c);
    chk({req, " ctrl err"}, 32'(c), 32'(exp_ctrl));
    bus_wr(3'd4, 8'h00);
    bus_rd(3'd4, c);
    chk("R9 err cleared", 32'(c), 32'h00);
  endtask

  localparam logic [15:0] RD_VEC [6] = '{16'h0000, 16'h0001, 16'h00FF,
                                         16'h1A37, 16'h3FFF, 16'hFFFF};

  initial begin
    logic [7:0] v;
    reg_addr = '0; reg_wdata = '0; reg_we = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 outputs", 32'({core_kill, core_stall, fl_rd, fl_erase}), 32'd0);
    for (int i = 0; i < 8; i++) begin
      bus_rd(3'(i), v);
      chk("R1 reg zero", 32'(v), 32'd0);
    end

    // table-driven reads: R2, R3
    for (int i = 0; i < 6; i++) do_read(RD_VEC[i], pat(RD_VEC[i]));

    // R4 read without program select
    bus_wr(3'd4, 8'h01);
    chk("R4 no access", 32'({fl_rd, core_kill}), 32'd0);
    @(negedge clk);
    chk("R4 no kill", 32'(core_kill), 32'd0);
    bus_rd(3'd4, v);
    chk("R4 ctrl", 32'(v), 32'h00);
    bus_rd(3'd2, v);
    chk("R4 data lo unchanged", 32'(v), 32'(pat(16'hFFFF) & 14'hFF));

    // R5 software data write and hold
    bus_wr(3'd2, 8'h5A);
    bus_wr(3'd3, 8'hFF);
    repeat (3) @(negedge clk);
    bus_rd(3'd2, v);
    chk("R5 data lo", 32'(v), 32'h5A);
    bus_rd(3'd3, v);
    chk("R5 data hi 6 bits", 32'(v), 32'h3F);

    // R11 key and unused offsets read zero
    bus_wr(3'd5, 8'h55);
    bus_rd(3'd5, v);
    chk("R11 key reads 0", 32'(v), 32'd0);
    bus_rd(3'd6, v);
    chk("R11 off6", 32'(v), 32'd0);
    bus_rd(3'd7, v);
    chk("R11 off7", 32'(v), 32'd0);
    bus_wr(3'd4, 8'h00);

    // R7/R10/R6 erase finished by done
    do_erase(16'h1A37, 12, 12);
    do_read(16'h1A20, 14'h3FFF);
    do_read(16'h1A3F, 14'h3FFF);
    do_read(16'h1A1F, pat(16'h1A1F));
    do_read(16'h1A40, pat(16'h1A40));

    // R10 erase finished by counter
    do_erase(16'h0405, 0, EC);
    do_read(16'h0400, 14'h3FFF);
    do_read(16'h041F, 14'h3FFF);
    do_read(16'h0420, pat(16'h0420));
    do_read(16'h03FF, pat(16'h03FF));

    // R12 used key does not carry over
    bus_wr(3'd5, 8'h55);
    bus_wr(3'd5, 8'hAA);
    bus_wr(3'd4, 8'h96);
    repeat (EC + 4) @(negedge clk);
    bus_wr(3'd4, 8'h96);
    refused("R12", 8'h9C);

    // R8 intervening write
    bus_wr(3'd5, 8'h55);
    bus_wr(3'd0, 8'h10);
    bus_wr(3'd5, 8'hAA);
    bus_wr(3'd4, 8'h96);
    refused("R8 intervening", 8'h9C);

    // R8 wrong second byte
    bus_wr(3'd5, 8'h55);
    bus_wr(3'd5, 8'h56);
    bus_wr(3'd5, 8'hAA);
    bus_wr(3'd4, 8'h96);
    refused("R8 wrong byte", 8'h9C);

    // R9 no key at all
    bus_wr(3'd4, 8'h96);
    refused("R9 no key", 8'h9C);

    // R9 write enable clear with valid key
    bus_wr(3'd5, 8'h55);
    bus_wr(3'd5, 8'hAA);
    bus_wr(3'd4, 8'h92);
    refused("R9 no wen", 8'h98);

    // R9 erase select clear with valid key
    bus_wr(3'd5, 8'h55);
    bus_wr(3'd5, 8'hAA);
    bus_wr(3'd4, 8'h86);
    refused("R9 no erase sel", 8'h8C);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule